// File: doc/BRIEF.md
# Bonded Transceiver Reset Sequencer

This block brings a bonded transceiver group out of reset after power-up. The group has one shared PLL, one transmit path and `NUM_CH` receive channels. The sequencer holds the PLL in reset for a fixed number of cycles. It then waits for the PLL to report lock and releases the transmit logic. Next it releases the receive analog front end once the offset-calibration flag is clear. Last, it releases the receive digital logic once every channel's frequency detector has held lock for a settle interval.

The lock, busy and frequency-lock inputs come from other clock domains. Each passes through a two-flop synchroniser before the state machine uses it. If the PLL loses lock after the transmit release, the whole sequence starts over, and a synchronous restart input does the same. All timing values are parameters in clock cycles.

Top module: `bonded_rst_seq`

## Requirements
- R1: After reset deassertion, and after a restart, `pll_rst` stays high for exactly `PLL_RST_CYC` clock cycles and `ready` is low.
- R2: While `pll_rst` is high, `tx_rst`, `rxa_rst` and `rxd_rst` are all high.
- R3: After `pll_rst` falls, `tx_rst` stays high until the synchronised PLL lock is high. With the sequencer already waiting, `tx_rst` falls 3 cycles after `pll_lock_a` rises (two synchroniser stages plus one state update).
- R4: `rxa_rst` falls `RXA_DLY` cycles after `tx_rst` falls when the busy flag is low. While the synchronised busy flag is high, `rxa_rst` stays high and the delay count restarts. After `cal_busy_a` falls, `rxa_rst` falls `RXA_DLY`+2 cycles later.
- R5: `rxd_rst` falls only after all `NUM_CH` bits of `freq_lock_a` have been high for `SETTLE_CYC` consecutive synchronised cycles. If all bits rise together while `rxa_rst` is low, the latency is `SETTLE_CYC`+2 cycles.
- R6: If any bit of `freq_lock_a` drops before `rxd_rst` falls, the settle count restarts from zero.
- R7: Once `tx_rst` is low, a fall of `pll_lock_a` raises `pll_rst` 3 cycles later, together with all other resets.
- R8: A high `restart` sampled on a clock edge sets all four resets high from that edge on.
- R9: `ready` is high exactly when all four resets are low.
- R10: After `rxd_rst` has fallen, drops of `freq_lock_a` have no effect: `ready` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel clock |
| rst_n | input | 1 | Asynchronous power-up reset, active low |
| restart | input | 1 | Synchronous request to rerun the sequence |
| pll_lock_a | input | 1 | PLL lock status, asynchronous |
| cal_busy_a | input | 1 | Offset-calibration busy flag, asynchronous |
| freq_lock_a | input | NUM_CH | Per-channel receive frequency lock, asynchronous |
| pll_rst | output | 1 | PLL analog reset |
| tx_rst | output | 1 | Transmit digital reset |
| rxa_rst | output | 1 | Receive analog reset |
| rxd_rst | output | 1 | Receive digital reset |
| ready | output | 1 | All resets released |

## Verification
On every cycle, the assertions check the following:
- the nesting of the resets and the release order;
- the minimum PLL reset width;
- that each release only happens with its synchronised condition present;
- the reaction to lock loss and restart;
- the coherence of `ready`.

The exact latencies through the synchronisers, the restart of the delay count under busy and the settle count under a frequency-lock glitch can only be shown by the bench's scenarios. The same holds for the way frequency-lock drops are ignored after release. The bench measures each of these as a cycle count at the ports.

// File: rtl/bonded_rst_seq.sv
module bonded_rst_seq #(
  parameter int NUM_CH      = 4,
  parameter int PLL_RST_CYC = 125,
  parameter int RXA_DLY     = 2,
  parameter int SETTLE_CYC  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              pll_lock_a,
  input  logic              cal_busy_a,
  input  logic [NUM_CH-1:0] freq_lock_a,
  output logic              pll_rst,
  output logic              tx_rst,
  output logic              rxa_rst,
  output logic              rxd_rst,
  output logic              ready
);
  localparam int MAXC = (PLL_RST_CYC > SETTLE_CYC) ?
                        ((PLL_RST_CYC > RXA_DLY) ? PLL_RST_CYC : RXA_DLY) :
                        ((SETTLE_CYC > RXA_DLY) ? SETTLE_CYC : RXA_DLY);
  localparam int CW = $clog2(MAXC + 1);

  typedef enum logic [2:0] {ST_PLL, ST_LOCK, ST_TX, ST_RXA, ST_RUN} st_t;

  st_t             st;
  logic [CW-1:0]   cnt;
  logic            lock_m, lock_s, busy_m, busy_s;
  logic [NUM_CH-1:0] fl_m, fl_s;
  logic            all_fl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {lock_m, lock_s, busy_m, busy_s} <= '0;
      fl_m <= '0;
      fl_s <= '0;
    end else begin
      lock_m <= pll_lock_a;
      lock_s <= lock_m;
      busy_m <= cal_busy_a;
      busy_s <= busy_m;
      fl_m   <= freq_lock_a;
      fl_s   <= fl_m;
    end
  end

  assign all_fl = &fl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_PLL;
      cnt <= '0;
    end else if (restart) begin
      st  <= ST_PLL;
      cnt <= '0;
    end else begin
      case (st)
        ST_PLL:
          if (cnt == CW'(PLL_RST_CYC - 1)) begin
            st  <= ST_LOCK;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        ST_LOCK: begin
          cnt <= '0;
          if (lock_s) st <= ST_TX;
        end
        ST_TX:
          if (!lock_s) begin
            st  <= ST_PLL;
            cnt <= '0;
          end else if (busy_s) cnt <= '0;
          else if (cnt == CW'(RXA_DLY - 1)) begin
            st  <= ST_RXA;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        ST_RXA:
          if (!lock_s) begin
            st  <= ST_PLL;
            cnt <= '0;
          end else if (!all_fl) cnt <= '0;
          else if (cnt == CW'(SETTLE_CYC - 1)) begin
            st  <= ST_RUN;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        ST_RUN:
          if (!lock_s) begin
            st  <= ST_PLL;
            cnt <= '0;
          end
        default: begin
          st  <= ST_PLL;
          cnt <= '0;
        end
      endcase
    end
  end

  assign pll_rst = (st == ST_PLL);
  assign tx_rst  = (st == ST_PLL) || (st == ST_LOCK);
  assign rxa_rst = tx_rst || (st == ST_TX);
  assign rxd_rst = (st != ST_RUN);
  assign ready   = (st == ST_RUN);
endmodule

// File: rtl/bonded_rst_seq_chk.sv
module bonded_rst_seq_chk #(
  parameter int PLL_RST_CYC = 125
) (
  input logic clk,
  input logic rst_n,
  input logic restart,
  input logic lock_s,
  input logic all_fl,
  input logic pll_rst,
  input logic tx_rst,
  input logic rxa_rst,
  input logic rxd_rst,
  input logic ready
);
  logic [15:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_cnt <= '0;
    else if (!pll_rst) hi_cnt <= '0;
    else if (hi_cnt != 16'hFFFF) hi_cnt <= hi_cnt + 1'b1;
  end

  AST_PLL_MIN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pll_rst) |-> (hi_cnt >= 16'(PLL_RST_CYC))); // R1
  AST_PLL_HOLDS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    pll_rst |-> (tx_rst && rxa_rst && rxd_rst)); // R2
  AST_TX_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_rst) |-> $past(lock_s)); // R3
  AST_RXA_AFTER_TX: assert property (@(posedge clk) disable iff (!rst_n)
    !rxa_rst |-> !tx_rst); // R4
  AST_RXD_AFTER_RXA: assert property (@(posedge clk) disable iff (!rst_n)
    !rxd_rst |-> !rxa_rst); // R5
  AST_RXD_NEEDS_FL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rxd_rst) |-> $past(all_fl)); // R5
  AST_LOCK_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_rst && !lock_s && !restart) |=> pll_rst); // R7
  AST_RESTART_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (pll_rst && tx_rst && rxa_rst && rxd_rst)); // R8
  AST_READY_COHERENT: assert property (@(posedge clk) disable iff (!rst_n)
    ready == (!pll_rst && !tx_rst && !rxa_rst && !rxd_rst)); // R9
endmodule

bind bonded_rst_seq bonded_rst_seq_chk #(.PLL_RST_CYC(PLL_RST_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .restart(restart), .lock_s(lock_s), .all_fl(all_fl),
  .pll_rst(pll_rst), .tx_rst(tx_rst), .rxa_rst(rxa_rst), .rxd_rst(rxd_rst),
  .ready(ready)
);

// File: tb/bonded_rst_seq_bench.sv
module bonded_rst_seq_bench;
  localparam int NUM_CH = 4, P = 125, D = 2, S = 64, SYNC = 2;

  logic clk = 0, rst_n = 0, restart = 0, lock = 0, busy = 0;
  logic [NUM_CH-1:0] fl = '0;
  logic pll_rst, tx_rst, rxa_rst, rxd_rst, ready;
  int tests = 0, fails = 0;
  logic done = 0;

  always #4 clk = ~clk;

  bonded_rst_seq #(.NUM_CH(NUM_CH), .PLL_RST_CYC(P), .RXA_DLY(D), .SETTLE_CYC(S))
    u_bonded_rst_seq (.clk, .rst_n, .restart, .pll_lock_a(lock), .cal_busy_a(busy),
                      .freq_lock_a(fl), .pll_rst, .tx_rst, .rxa_rst, .rxd_rst, .ready);

  function automatic int exp_sync_lat(int extra); return SYNC + extra; endfunction
  function automatic logic [3:0] all_rst(); return {pll_rst, tx_rst, rxa_rst, rxd_rst}; endfunction
  function automatic logic sig(int w);
    case (w)
      0: return pll_rst;
      1: return tx_rst;
      2: return rxa_rst;
      default: return rxd_rst;
    endcase
  endfunction

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic meas(int w, logic target, output int n);
    n = 0;
    while (n < 5000) begin
      @(negedge clk);
      n++;
      if (sig(w) == target) break;
    end
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int n, k, b;
    void'($urandom(32'd20240611));
    cyc(3);
    chk("R1 reset state resets", int'(all_rst()), 15);
    chk("R1 reset state ready", int'(ready), 0);
    busy = 1;
    rst_n = 1;
    meas(0, 1'b0, n);
    chk("R1 pll reset width", n, P);
    chk("R2 resets held at pll release", int'({tx_rst, rxa_rst, rxd_rst}), 7);
    cyc(5 + int'($urandom_range(30)));
    chk("R3 tx held without lock", int'(tx_rst), 1);
    lock = 1;
    meas(1, 1'b0, n);
    chk("R3 tx latency from lock", n, exp_sync_lat(1));
    cyc(3 + int'($urandom_range(20)));
    chk("R4 rxa held while busy", int'(rxa_rst), 1);
    busy = 0;
    meas(2, 1'b0, n);
    chk("R4 rxa latency from busy fall", n, exp_sync_lat(D));
    fl = '1;
    k = 5 + int'($urandom_range(S - 12));
    cyc(k);
    b = int'($urandom_range(NUM_CH - 1));
    fl[b] = 1'b0;
    cyc(1 + int'($urandom_range(2)));
    fl = '1;
    cyc(2);
    chk("R6 rxd held after glitch", int'(rxd_rst), 1);
    meas(3, 1'b0, n);
    chk("R6 settle restarted after glitch", n + 2, exp_sync_lat(S));
    chk("R9 ready after all released", int'(ready), 1);
    fl[int'($urandom_range(NUM_CH - 1))] = 1'b0;
    cyc(6);
    chk("R10 ready kept after fl drop", int'(ready), 1);
    chk("R10 rxd kept after fl drop", int'(rxd_rst), 0);
    fl = '1;
    cyc(2);

    lock = 0;
    meas(0, 1'b1, n);
    chk("R7 pll reset latency on lock loss", n, exp_sync_lat(1));
    chk("R7 all resets on lock loss", int'(all_rst()), 15);
    chk("R9 ready low on lock loss", int'(ready), 0);
    lock = 1;
    meas(0, 1'b0, n);
    chk("R1 pll reset width after lock loss", n, P);
    meas(1, 1'b0, n);
    chk("R3 tx with lock already present", n, 1);
    meas(2, 1'b0, n);
    chk("R4 rxa delay with busy low", n, D);
    meas(3, 1'b0, n);
    chk("R5 rxd settle with fl present", n, S);

    for (int it = 0; it < 4; it++) begin
      cyc(int'($urandom_range(P + S + 40)));
      restart = 1;
      @(negedge clk);
      restart = 0;
      chk("R8 all resets after restart", int'(all_rst()), 15);
      chk("R8 ready low after restart", int'(ready), 0);
      meas(0, 1'b0, n);
      chk("R1 pll reset width after restart", n, P);
      meas(1, 1'b0, n);
      chk("R3 tx after restart", n, 1);
      meas(2, 1'b0, n);
      chk("R4 rxa after restart", n, D);
      meas(3, 1'b0, n);
      chk("R5 rxd after restart", n, S);
    end

    fl = '0;
    restart = 1;
    @(negedge clk);
    restart = 0;
    meas(2, 1'b0, n);
    cyc(10);
    fl = '1;
    meas(3, 1'b0, n);
    chk("R5 rxd latency from fl rise", n, exp_sync_lat(S));
    chk("R9 ready at end", int'(ready), 1);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule